// File: doc/BRIEF.md
# Requester ID Translation Table

This block sits in the request and completion paths of a bridge made of two endpoints placed back to back. Each outbound request gives up its original requester ID. The block puts in an ID built from the bridge's own ID, with a table index in the low bits of the function field. The original ID is kept in a small table, together with a count of the requests still outstanding under it.

Completions come back carrying the substituted ID. The index in their low bits selects the table entry directly, and the block restores the original requester ID. A final completion lowers the entry's count, and the entry frees when the count reaches zero. Two hosts that both use requester ID zero can therefore exchange reads without completions reaching the wrong side. A completion that points at an empty entry is dropped and flagged as unexpected. A flush input empties the whole table at once.

Both paths are combinational from input to output. The table updates on the clock edge.

Top module: `rid_xlate_table`

## Requirements
- R1: After reset every entry is empty and `req_ready` is high.
- R2: An accepted request leaves with `req_out_valid` high in the same cycle. Its `req_out_rid` equals `bridge_id` with the low IDX_W bits (3 for 8 entries) replaced by the table index.
- R3: A request whose original ID already has a live entry reuses that entry's index.
- R4: A request with a new original ID takes the lowest-numbered empty entry.
- R5: A completion whose low IDX_W ID bits select a live entry leaves in the same cycle with `cpl_out_valid` high. Its `cpl_out_rid` is the stored original ID.
- R6: A completion with `cpl_last` low leaves the count unchanged. A completion with `cpl_last` high lowers the count by one, and the entry frees when the count reaches zero.
- R7: A request with a new ID while all entries are live is stalled: `req_ready` and `req_out_valid` stay low. It is accepted once an entry frees.
- R8: A completion that selects an empty entry produces no `cpl_out_valid`, raises `cpl_unexp` for that cycle and changes no entry.
- R9: A request that hits an entry whose count is at its maximum, 2^CNT_W-1, is stalled.
- R10: A cycle with `flush` high empties every entry from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the whole table |
| bridge_id | input | RID_W | The bridge's own requester ID |
| req_valid | input | 1 | Outbound request present |
| req_rid | input | RID_W | Original requester ID of the request |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_out_valid | output | 1 | Translated request leaving |
| req_out_rid | output | RID_W | Substituted requester ID |
| cpl_valid | input | 1 | Returning completion present |
| cpl_rid | input | RID_W | Requester ID carried by the completion |
| cpl_last | input | 1 | Completion is the final one for its request |
| cpl_out_valid | output | 1 | Completion leaving with its ID restored |
| cpl_out_rid | output | RID_W | Restored original requester ID |
| cpl_unexp | output | 1 | Completion selected an empty entry and was dropped |

## Verification
The bench uses the default 16-bit IDs and eight entries. Filling the table therefore takes only eight requests, which puts the stall on a ninth requester within easy reach. CNT_W is set to 2, so an entry saturates after three outstanding requests. That makes the per-entry stall and the release after one final completion short, directed cases.

// File: rtl/rid_xlate_table.sv
module rid_xlate_table #(
  parameter int RID_W   = 16,
  parameter int ENTRIES = 8,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [RID_W-1:0] bridge_id,
  input  logic             req_valid,
  input  logic [RID_W-1:0] req_rid,
  output logic             req_ready,
  output logic             req_out_valid,
  output logic [RID_W-1:0] req_out_rid,
  input  logic             cpl_valid,
  input  logic [RID_W-1:0] cpl_rid,
  input  logic             cpl_last,
  output logic             cpl_out_valid,
  output logic [RID_W-1:0] cpl_out_rid,
  output logic             cpl_unexp
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [RID_W-1:0] rid_q [ENTRIES];
  logic [CNT_W-1:0] cnt_q [ENTRIES];

  logic             hit, free_any;
  logic [IDX_W-1:0] hit_idx, free_idx, req_idx, cpl_idx;
  logic             fire, cpl_live, cpl_done;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (cnt_q[i] != '0 && rid_q[i] == req_rid) begin
        hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (cnt_q[i] == '0) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign req_idx       = hit ? hit_idx : free_idx;
  assign req_ready     = hit ? (cnt_q[hit_idx] != CMAX) : free_any;
  assign fire          = req_valid & req_ready;
  assign req_out_valid = fire;
  assign req_out_rid   = {bridge_id[RID_W-1:IDX_W], req_idx};

  assign cpl_idx       = cpl_rid[IDX_W-1:0];
  assign cpl_live      = cnt_q[cpl_idx] != '0;
  assign cpl_out_valid = cpl_valid & cpl_live;
  assign cpl_out_rid   = rid_q[cpl_idx];
  assign cpl_unexp     = cpl_valid & ~cpl_live;
  assign cpl_done      = cpl_out_valid & cpl_last;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic inc, dec;
    assign inc = fire && req_idx == IDX_W'(g);
    assign dec = cpl_done && cpl_idx == IDX_W'(g);
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        cnt_q[g] <= '0;
      end else begin
        cnt_q[g] <= cnt_q[g] + CNT_W'(inc) - CNT_W'(dec);
      end
      if (!rst_n) rid_q[g] <= '0;
      else if (inc && !hit) rid_q[g] <= req_rid;
    end
  end
endmodule

module rid_xlate_table_chk #(
  parameter int RID_W = 16,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic [RID_W-1:0] bridge_id,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_out_valid,
  input logic [RID_W-1:0] req_out_rid,
  input logic             cpl_valid,
  input logic             cpl_out_valid,
  input logic             cpl_unexp
);
  // R2
  sub_id_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_out_valid |-> req_out_rid[RID_W-1:IDX_W] == bridge_id[RID_W-1:IDX_W]);
  // R7
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> !req_out_valid);
  // R8
  unexp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpl_unexp && cpl_out_valid));
  // R5
  cpl_needs_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_out_valid || cpl_unexp) |-> cpl_valid);
  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !cpl_out_valid);
  // R1
  reset_ready_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> req_ready);
endmodule

bind rid_xlate_table rid_xlate_table_chk #(.RID_W(RID_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .bridge_id(bridge_id),
  .req_valid(req_valid), .req_ready(req_ready), .req_out_valid(req_out_valid),
  .req_out_rid(req_out_rid), .cpl_valid(cpl_valid), .cpl_out_valid(cpl_out_valid),
  .cpl_unexp(cpl_unexp)
);

// File: tb/rid_xlate_table_bench.sv
module rid_xlate_table_bench;
  logic clk = 0, rst_n = 0, flush = 0;
  logic [15:0] bridge_id = 16'hAB28;
  logic req_valid = 0, cpl_valid = 0, cpl_last = 0;
  logic [15:0] req_rid = 0, cpl_rid = 0;
  logic req_ready, req_out_valid, cpl_out_valid, cpl_unexp;
  logic [15:0] req_out_rid, cpl_out_rid;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  rid_xlate_table #(.RID_W(16), .ENTRIES(8), .CNT_W(2)) u_rid_xlate_table (
    .clk(clk), .rst_n(rst_n), .flush(flush), .bridge_id(bridge_id),
    .req_valid(req_valid), .req_rid(req_rid), .req_ready(req_ready),
    .req_out_valid(req_out_valid), .req_out_rid(req_out_rid),
    .cpl_valid(cpl_valid), .cpl_rid(cpl_rid), .cpl_last(cpl_last),
    .cpl_out_valid(cpl_out_valid), .cpl_out_rid(cpl_out_rid), .cpl_unexp(cpl_unexp));

  function automatic logic [15:0] sub(input int idx);
    return {bridge_id[15:3], 3'(idx)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_req(input logic [15:0] rid, input bit exp_ok, input int idx, input string req);
    @(negedge clk);
    req_valid = 1; req_rid = rid;
    #1;
    chk(req_ready == exp_ok && req_out_valid == exp_ok, req, {req_ready, req_out_valid}, {exp_ok, exp_ok});
    if (exp_ok) chk(req_out_rid == sub(idx), req, req_out_rid, sub(idx));
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic send_cpl(input int idx, input bit last, input bit exp_v, input logic [15:0] exp_rid, input string req);
    @(negedge clk);
    cpl_valid = 1; cpl_rid = sub(idx); cpl_last = last;
    #1;
    chk(cpl_out_valid == exp_v && cpl_unexp == !exp_v, req, {cpl_out_valid, cpl_unexp}, {exp_v, !exp_v});
    if (exp_v) chk(cpl_out_rid == exp_rid, req, cpl_out_rid, exp_rid);
    @(posedge clk); #1 cpl_valid = 0; cpl_last = 0;
  endtask

  task automatic do_flush;
    @(negedge clk); flush = 1;
    @(posedge clk); #1 flush = 0;
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
    send_cpl(0, 1, 0, 0, "R1 R8 empty table after reset");
  endtask

  task automatic t_basic;
    send_req(16'h0000, 1, 0, "R2 R4 first requester");
    send_req(16'h0100, 1, 1, "R4 second requester lowest free");
    send_req(16'h0000, 1, 0, "R3 reuse live entry");
    send_cpl(0, 0, 1, 16'h0000, "R5 restore id");
    send_cpl(0, 1, 1, 16'h0000, "R6 final lowers count");
    send_cpl(0, 1, 1, 16'h0000, "R6 entry still live");
    send_cpl(0, 1, 0, 0, "R6 R8 entry freed");
    send_cpl(1, 1, 1, 16'h0100, "R5 restore second id");
    send_req(16'h0200, 1, 0, "R4 freed entry reused");
    do_flush();
  endtask

  task automatic t_full;
    for (int i = 0; i < 8; i++) send_req(16'h0010 + 16'(i), 1, i, "R4 fill table");
    send_req(16'h0099, 0, 0, "R7 ninth requester stalls");
    send_cpl(5, 1, 1, 16'h0015, "R5 release entry 5");
    send_req(16'h0099, 1, 5, "R7 ninth requester accepted");
    do_flush();
  endtask

  task automatic t_sat;
    for (int i = 0; i < 3; i++) send_req(16'h0042, 1, 0, "R9 fill count");
    send_req(16'h0042, 0, 0, "R9 saturated entry stalls");
    send_cpl(0, 1, 1, 16'h0042, "R9 one completes");
    send_req(16'h0042, 1, 0, "R9 accepted again");
  endtask

  task automatic t_flush;
    do_flush();
    send_cpl(0, 0, 0, 0, "R10 flushed entry empty");
    send_req(16'h0777, 1, 0, "R10 table reusable");
    send_cpl(0, 1, 1, 16'h0777, "R10 new entry restores");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_basic();
    t_full();
    t_sat();
    t_flush();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule